// File: doc/BRIEF.md
# Pixel Window Strobe Controller

This block decides, line by line, which pixel clocks carry active picture data on the pixel input port. A mode bit selects how the window strobe works. When the strobe is an output, the block drives it and raises it at a programmed point after the start of the line. That point is the sum of four programmed interval lengths: sync, gap, burst and colour back porch. When the strobe is an input, the host raises it a fixed four clocks ahead of its first valid pixel, and the block lines that data up with the end of the colour back porch.

The block does not count lines or process pixels. It takes a one-clock line-start flag from the timing generator. It returns a registered copy of each accepted pixel, a pixel-valid qualifier and a porch-extension request. The request asks the timing generator to hold the back porch open when the host's data arrives late.

Top module: `pixwin_ctl`

## Requirements
- R1: After reset, `pix_valid`, `ext_req`, `win_out`, `win_oe` and `pix_out` are all low or zero.
- R2: `win_oe` is `dir_out` delayed by one clock. `dir_out` = 1 selects output mode and `dir_out` = 0 selects input mode.
- R3: In output mode, let N = `len_sync + len_bgap + len_burst + len_cbp`. `win_out` and `pix_valid` rise after the Nth clock edge following the edge at which `line_start` is sampled high. `pix_out` then holds the `pix_in` value sampled at that edge.
- R4: Each accepted pixel is the `pix_in` sampled at that edge. `pix_valid` stays high for exactly `act_len` clocks and then falls. `win_out` is high only while `pix_valid` is high, so it is low during blanking.
- R5: In input mode, a strobe rising edge is sampled at edge E. Pixel-valid starts at edge max(E+4, N). If E+4 < N, the pixels presented before edge N are discarded: `pix_valid` = 0 and `pix_out` = 0.
- R6: In input mode with E+4 > N, `ext_req` is high from edge N until edge E+4, and pixel-valid starts at edge E+4.
- R7: In input mode with E+4 = N, pixel-valid starts at edge N and `ext_req` never rises.
- R8: In input mode, `win_in` sampled low during the active run ends `pix_valid` at that edge.
- R9: Only the first strobe rising edge sampled between `line_start` and the start of pixel-valid is honoured. Later edges and edges after the active run are ignored.
- R10: `line_start` sampled high clears `pix_valid`, `ext_req` and `win_out` at that edge and restarts the line timing, even during an active run.
- R11: `ext_req` and `pix_valid` are never high together, and `ext_req` never rises in output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_out | input | 1 | Mode bit: 1 = block drives the strobe, 0 = host drives it |
| line_start | input | 1 | One-clock flag at the start of line sync |
| len_sync | input | CW | Sync interval length in clocks |
| len_bgap | input | CW | Gap between sync and burst in clocks |
| len_burst | input | CW | Burst interval length in clocks |
| len_cbp | input | CW | Colour back porch length in clocks |
| act_len | input | AW | Active pixels per line |
| win_in | input | 1 | Window strobe from the host (input mode) |
| pix_in | input | DW | Pixel data port |
| win_out | output | 1 | Window strobe driven by the block (output mode) |
| win_oe | output | 1 | Output enable for the strobe pad |
| pix_out | output | DW | Accepted pixel, zero when not valid |
| pix_valid | output | 1 | Pixel qualifier |
| ext_req | output | 1 | Request to extend the colour back porch |

## Verification
If the porch position counter is wrong, the first valid pixel moves off edge N. That shows up as a misplaced `pix_valid` rise on the very first line. A lead counter or first-edge latch that is stuck or retriggers shifts the start edge in the late-strobe cases, and it changes how long `ext_req` stays high. An active-run counter that is off by one makes the run one clock short or long at its tail, about `act_len` clocks after the start. Because `pix_out` carries the edge number as data, a misaligned capture shows at once as a wrong value on the first valid pixel.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Line phases seen by the window state machine
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BLANK  = 2'd1,
    PH_WAIT   = 2'd2,
    PH_ACTIVE = 2'd3
  } pwc_phase_e;

endpackage

// File: rtl/pwc_porch_timer.sv
module pwc_porch_timer #(
  parameter int CW = 8,
  localparam int TW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_bgap,
  input  logic [CW-1:0] len_burst,
  input  logic [CW-1:0] len_cbp,
  output logic          porch_reached
);

  logic [TW-1:0] total;
  logic [TW-1:0] pos;

  assign total = TW'(len_sync) + TW'(len_bgap) + TW'(len_burst) + TW'(len_cbp);

  // pos holds k before the k-th edge after the line-start edge, then saturates
  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (line_start) begin
      pos <= TW'(1);
    end else if (pos != '0 && pos < total) begin
      pos <= pos + TW'(1);
    end
  end

  assign porch_reached = (pos != '0) && (pos >= total);

  // R3
  pos_keeps_running_chk: assert property (@(posedge clk) disable iff (rst)
    (pos != '0 && !line_start) |=> (pos != '0));

endmodule

// File: rtl/pwc_lead_tracker.sv
module pwc_lead_tracker #(
  parameter int LEAD = 4,
  localparam int LW = $clog2(LEAD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic armed,
  input  logic win_in,
  output logic lead_ready
);

  logic          win_d;
  logic          seen;
  logic [LW-1:0] lead_cnt;
  logic          rise;

  assign rise = win_in & ~win_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_d <= 1'b0;
    end else begin
      win_d <= win_in;
    end
  end

  // First honoured edge per line starts a saturating lead counter
  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      seen     <= 1'b0;
      lead_cnt <= '0;
    end else if (armed && !seen && rise) begin
      seen     <= 1'b1;
      lead_cnt <= LW'(1);
    end else if (seen && lead_cnt < LW'(LEAD)) begin
      lead_cnt <= lead_cnt + LW'(1);
    end
  end

  assign lead_ready = seen && (lead_cnt >= LW'(LEAD));

  // R9
  unarmed_edge_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && !seen) |=> !seen);

  // R9
  first_edge_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !line_start) |=> (seen && $stable(seen)));

endmodule

// File: rtl/pwc_window_fsm.sv
module pwc_window_fsm
  import pwc_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_out,
  input  logic          line_start,
  input  logic          porch_reached,
  input  logic          lead_ready,
  input  logic          win_in,
  input  logic [DW-1:0] pix_in,
  input  logic [AW-1:0] act_len,
  output logic          armed,
  output logic          pix_valid,
  output logic [DW-1:0] pix_out,
  output logic          ext_req,
  output logic          win_out
);

  pwc_phase_e    phase;
  logic [AW-1:0] run_cnt;
  logic          go;
  logic          stop;

  assign go    = dir_out || lead_ready;
  assign stop  = (!dir_out && !win_in) || (run_cnt >= act_len);
  assign armed = (phase == PH_BLANK) || (phase == PH_WAIT);

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      phase     <= rst ? PH_IDLE : PH_BLANK;
      pix_valid <= 1'b0;
      pix_out   <= '0;
      ext_req   <= 1'b0;
      win_out   <= 1'b0;
      run_cnt   <= '0;
    end else begin
      unique case (phase)
        PH_BLANK, PH_WAIT: begin
          if ((phase == PH_WAIT || porch_reached) && go) begin
            phase     <= PH_ACTIVE;
            pix_valid <= 1'b1;
            pix_out   <= pix_in;
            ext_req   <= 1'b0;
            win_out   <= dir_out;
            run_cnt   <= AW'(1);
          end else if (phase == PH_BLANK && porch_reached) begin
            phase   <= PH_WAIT;
            ext_req <= 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (stop) begin
            phase     <= PH_IDLE;
            pix_valid <= 1'b0;
            pix_out   <= '0;
            win_out   <= 1'b0;
          end else begin
            pix_out <= pix_in;
            win_out <= dir_out;
            run_cnt <= run_cnt + AW'(1);
          end
        end
        default: begin
          pix_valid <= 1'b0;
          ext_req   <= 1'b0;
        end
      endcase
    end
  end

  // R11
  valid_ext_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pix_valid && ext_req));

  // R11
  ext_drops_in_out_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_req && dir_out && !line_start) |=> !ext_req);

  // R4
  strobe_inside_valid_chk: assert property (@(posedge clk) disable iff (rst)
    win_out |-> pix_valid);

  // R10
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (!pix_valid && !ext_req && !win_out));

  // R4
  run_count_live_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (run_cnt != '0));

endmodule

// File: rtl/pixwin_ctl.sv
module pixwin_ctl
  import pwc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int AW   = 10,
  parameter int LEAD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_out,
  input  logic          line_start,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_bgap,
  input  logic [CW-1:0] len_burst,
  input  logic [CW-1:0] len_cbp,
  input  logic [AW-1:0] act_len,
  input  logic          win_in,
  input  logic [DW-1:0] pix_in,
  output logic          win_out,
  output logic          win_oe,
  output logic [DW-1:0] pix_out,
  output logic          pix_valid,
  output logic          ext_req
);

  logic porch_reached;
  logic lead_ready;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_oe <= 1'b0;
    end else begin
      win_oe <= dir_out;
    end
  end

  pwc_porch_timer #(.CW(CW)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .line_start   (line_start),
    .len_sync     (len_sync),
    .len_bgap     (len_bgap),
    .len_burst    (len_burst),
    .len_cbp      (len_cbp),
    .porch_reached(porch_reached)
  );

  pwc_lead_tracker #(.LEAD(LEAD)) u_lead (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .armed     (armed),
    .win_in    (win_in),
    .lead_ready(lead_ready)
  );

  pwc_window_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .dir_out      (dir_out),
    .line_start   (line_start),
    .porch_reached(porch_reached),
    .lead_ready   (lead_ready),
    .win_in       (win_in),
    .pix_in       (pix_in),
    .act_len      (act_len),
    .armed        (armed),
    .pix_valid    (pix_valid),
    .pix_out      (pix_out),
    .ext_req      (ext_req),
    .win_out      (win_out)
  );

  // R2
  pad_enable_chk: assert property (@(posedge clk) disable iff (rst)
    win_out |-> win_oe);

endmodule

// File: tb/pixwin_ctl_test.sv
module pixwin_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int AW = 10;
  localparam int NPOS = 14;   // 3 + 2 + 4 + 5
  localparam int ALEN = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir_out = 1'b0;
  logic          line_start = 1'b0;
  logic [CW-1:0] len_sync = 8'd3;
  logic [CW-1:0] len_bgap = 8'd2;
  logic [CW-1:0] len_burst = 8'd4;
  logic [CW-1:0] len_cbp = 8'd5;
  logic [AW-1:0] act_len = AW'(ALEN);
  logic          win_in = 1'b0;
  logic [DW-1:0] pix_in = '0;
  logic          win_out, win_oe, pix_valid, ext_req;
  logic [DW-1:0] pix_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic          rec_v [0:63];
  logic          rec_e [0:63];
  logic          rec_w [0:63];
  logic [DW-1:0] rec_p [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  pixwin_ctl #(.DW(DW), .CW(CW), .AW(AW), .LEAD(4)) uut (
    .clk(clk), .rst(rst), .dir_out(dir_out), .line_start(line_start),
    .len_sync(len_sync), .len_bgap(len_bgap), .len_burst(len_burst),
    .len_cbp(len_cbp), .act_len(act_len), .win_in(win_in), .pix_in(pix_in),
    .win_out(win_out), .win_oe(win_oe), .pix_out(pix_out),
    .pix_valid(pix_valid), .ext_req(ext_req)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int k, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, what, k, act, exp);
    end
  endtask

  function automatic logic [63:0] span(int a, int b);
    logic [63:0] r = '0;
    for (int i = a; i < b; i++) r[i] = 1'b1;
    return r;
  endfunction

  // Starts a line and records outputs after each edge; pix_in carries the edge number
  task automatic run_line(logic [63:0] pat, int m);
    line_start = 1'b1;
    win_in = pat[0];
    pix_in = '0;
    tick();
    line_start = 1'b0;
    rec_v[0] = pix_valid; rec_e[0] = ext_req; rec_w[0] = win_out; rec_p[0] = pix_out;
    for (int k = 1; k <= m; k++) begin
      win_in = pat[k];
      pix_in = DW'(k);
      tick();
      rec_v[k] = pix_valid; rec_e[k] = ext_req; rec_w[k] = win_out; rec_p[k] = pix_out;
    end
    win_in = 1'b0;
  endtask

  task automatic check_line(string req, int vs, int ve, int es, int ee, int m, bit wo);
    for (int k = 0; k <= m; k++) begin
      bit ev = (k >= vs) && (k < ve);
      bit ee_ = (k >= es) && (k < ee);
      chk(req, "pix_valid", k, 32'(rec_v[k]), 32'(ev));
      chk(req, "ext_req", k, 32'(rec_e[k]), 32'(ee_));
      chk(req, "win_out", k, 32'(rec_w[k]), 32'(wo && ev));
      chk(req, "pix_out", k, 32'(rec_p[k]), ev ? 32'(k) : 32'd0);
    end
  endtask

  task automatic set_mode(bit m);
    dir_out = m;
    tick();
    // R2: enable follows the mode bit one clock later
    chk("R2", "win_oe", 0, 32'(win_oe), 32'(m));
  endtask

  task automatic test_reset();
    // R1
    chk("R1", "pix_valid", 0, 32'(pix_valid), 0);
    chk("R1", "ext_req", 0, 32'(ext_req), 0);
    chk("R1", "win_out", 0, 32'(win_out), 0);
    chk("R1", "win_oe", 0, 32'(win_oe), 0);
    chk("R1", "pix_out", 0, 32'(pix_out), 0);
  endtask

  task automatic test_output_mode();
    set_mode(1'b1);
    run_line('0, 24);
    // R3 start at N, R4 run length, R11 no extension in output mode
    check_line("R3_R4_R11", NPOS, NPOS + ALEN, 99, 99, 24, 1'b1);
  endtask

  task automatic test_early();
    set_mode(1'b0);
    run_line(span(5, 45), 24);
    // R5: edge at 5, ready at 9, data before N discarded
    check_line("R5", NPOS, NPOS + ALEN, 99, 99, 24, 1'b0);
  endtask

  task automatic test_late();
    run_line(span(16, 45), 30);
    // R6: edge at 16, extension from N to 20
    check_line("R6", 20, 20 + ALEN, NPOS, 20, 30, 1'b0);
  endtask

  task automatic test_exact();
    run_line(span(10, 45), 24);
    // R7: E+4 equals N
    check_line("R7", NPOS, NPOS + ALEN, 99, 99, 24, 1'b0);
  endtask

  task automatic test_fall();
    run_line(span(5, 17), 24);
    // R8: strobe low at edge 17 ends the run early
    check_line("R8", NPOS, 17, 99, 99, 24, 1'b0);
  endtask

  task automatic test_first_edge();
    run_line(span(12, 13) | span(14, 22) | span(24, 40), 45);
    // R9: first edge at 12 honoured, re-rise at 14 and 24 ignored
    check_line("R9", 16, 16 + ALEN, NPOS, 16, 45, 1'b0);
  endtask

  task automatic test_restart();
    set_mode(1'b1);
    run_line('0, 16);
    check_line("R10", NPOS, 17, 99, 99, 16, 1'b1);
    run_line('0, 22);
    // R10: new line start clears the run and re-times from its own edge
    check_line("R10", NPOS, NPOS + ALEN, 99, 99, 22, 1'b1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    test_reset();
    test_output_mode();
    test_early();
    test_late();
    test_exact();
    test_fall();
    test_first_edge();
    test_restart();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule